// File: doc/BRIEF.md
# Seconds and Fraction Time Counter with Match Alarm

This block keeps time as a single 47-bit binary counter that advances once per cycle of its slow (32 kHz) clock. The upper 32 bits hold whole seconds and the lower 15 bits hold the fraction of a second. A 47-bit compare value is checked against the counter on every cycle. When they become equal, a sticky alarm flag is raised and also driven on a dedicated output.

Software reaches every register through a simple write port made of a strobe, a byte offset and a 32-bit data word. A separate read offset selects the word that appears combinationally on the read bus. After reset the counter holds still. It begins counting only after its seconds word has been written at least once and the count-enable bit has been set. A status word reports the alarm, a not-yet-valid indication and a security-violation indication. The last two are set by reset and are released together.

Top module: `sec_frac_timer`

## Requirements
- R1: After reset the reads return seconds 0 (offset 0x00), fraction 0 (0x04), alarm seconds 0xFFFFFFFF (0x08), alarm fraction 0 (0x0C), control 0 (0x10) and status 0x3 (0x14: bit 1 not-valid and bit 0 violation set, bit 4 alarm clear), with alarm_o low.
- R2: The counter holds its value unless control bit 3 is 1 and offset 0x00 has been written at least once since reset. Either condition alone leaves it frozen.
- R3: While running, the 47-bit counter adds one on every clock edge. Offset 0x04 reads its low 15 bits (zero-extended) and offset 0x00 reads bits 46:15, so a carry out of the fraction increments the seconds.
- R4: A write to 0x04 loads data bits 14:0 into the fraction and keeps the seconds. A write to 0x00 loads the 32-bit seconds and keeps the fraction. On that edge the load replaces the increment.
- R5: The clock edge after the counter first equals the 47-bit alarm value {0x08 word, 0x0C bits 14:0} sets status bit 4, and alarm_o follows it.
- R6: The alarm flag stays set until a status write (0x14) carries a 1 in bit 4. A status write with bit 4 at 0 leaves the flag unchanged.
- R7: The flag is set once per new match. While the counter stays equal to the alarm value, clearing the flag does not set it again.
- R8: Status bits 1 and 0 are cleared only by one status write with both data bits 1 and 0 equal to 1. A write carrying only one of the two leaves both bits set.
- R9: From all ones the counter wraps to seconds 0 and fraction 0 on the next running edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32 kHz counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| wr_addr_i | input | 5 | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Byte offset of the read |
| rd_data_o | output | 32 | Read data for rd_addr_i, combinational |
| alarm_o | output | 1 | Sticky alarm flag level |

## Verification
A corrupted count shows on the very next read of 0x00 or 0x04. Loads and carries are checked on the exact edge where they take effect, so an extra or missing increment shifts the value read by one. A wrong match register shows up as status bit 4 and alarm_o rising one edge early or late, or rising again while a match is held. A wrong validity state appears at once in the status word, because the bench reads it right after every partial and full release write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_SEC   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FRAC  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ASEC  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_AFRAC = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h14;

  localparam int unsigned BIT_RUN  = 3;
  localparam int unsigned BIT_ALM  = 4;
  localparam int unsigned BIT_NV   = 1;
  localparam int unsigned BIT_VIOL = 0;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15,
  localparam int unsigned CNT_W = SEC_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ld_sec_i,
  input  logic              ld_frac_i,
  input  logic [SEC_W-1:0]  sec_d_i,
  input  logic [FRAC_W-1:0] frac_d_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (ld_sec_i)  cnt_q <= {sec_d_i, cnt_q[FRAC_W-1:0]};
    else if (ld_frac_i) cnt_q <= {cnt_q[CNT_W-1:FRAC_W], frac_d_i};
    else if (run_i)     cnt_q <= cnt_q + 1'b1; // wraps at all ones
  end

  assign cnt_o = cnt_q;

  p_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_sec_i && !ld_frac_i) |=> $stable(cnt_q));
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !ld_sec_i && !ld_frac_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_frac_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_sec_i |=> (cnt_q[FRAC_W-1:0] == $past(cnt_q[FRAC_W-1:0])));
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm #(
  parameter int unsigned CNT_W = 47
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic hit, hit_q, flag_q;

  assign hit = (cnt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q <= hit;
      // new match wins over a same-cycle clear
      if (hit && !hit_q) flag_q <= 1'b1;
      else if (clr_i)    flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !hit_q) |=> flag_q);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  p_no_rearm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && hit_q) |=> !flag_q);
endmodule

// File: rtl/sec_frac_timer.sv
module sec_frac_timer
  import tmr_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alarm_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0]  cnt;
  logic [SEC_W-1:0]  asec_q;
  logic [FRAC_W-1:0] afrac_q;
  logic run_en_q, seeded_q, nv_q, viol_q, alm;
  logic wr_sec, wr_frac, wr_stat, release_ok;

  assign wr_sec     = wr_en_i && (wr_addr_i == OFS_SEC);
  assign wr_frac    = wr_en_i && (wr_addr_i == OFS_FRAC);
  assign wr_stat    = wr_en_i && (wr_addr_i == OFS_STAT);
  assign release_ok = wr_stat && wr_data_i[BIT_NV] && wr_data_i[BIT_VIOL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asec_q   <= '1;
      afrac_q  <= '0;
      run_en_q <= 1'b0;
      seeded_q <= 1'b0;
      nv_q     <= 1'b1;
      viol_q   <= 1'b1;
    end else begin
      if (wr_en_i && wr_addr_i == OFS_ASEC)  asec_q   <= wr_data_i[SEC_W-1:0];
      if (wr_en_i && wr_addr_i == OFS_AFRAC) afrac_q  <= wr_data_i[FRAC_W-1:0];
      if (wr_en_i && wr_addr_i == OFS_CTRL)  run_en_q <= wr_data_i[BIT_RUN];
      if (wr_sec) seeded_q <= 1'b1;
      if (release_ok) begin
        nv_q   <= 1'b0;
        viol_q <= 1'b0;
      end
    end
  end

  tmr_count #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_en_q && seeded_q),
    .ld_sec_i (wr_sec),
    .ld_frac_i(wr_frac),
    .sec_d_i  (wr_data_i[SEC_W-1:0]),
    .frac_d_i (wr_data_i[FRAC_W-1:0]),
    .cnt_o    (cnt)
  );

  tmr_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt),
    .cmp_i ({asec_q, afrac_q}),
    .clr_i (wr_stat && wr_data_i[BIT_ALM]),
    .flag_o(alm)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      OFS_SEC:   rd_data_o = DATA_W'(cnt[CNT_W-1:FRAC_W]);
      OFS_FRAC:  rd_data_o = DATA_W'(cnt[FRAC_W-1:0]);
      OFS_ASEC:  rd_data_o = DATA_W'(asec_q);
      OFS_AFRAC: rd_data_o = DATA_W'(afrac_q);
      OFS_CTRL:  rd_data_o[BIT_RUN] = run_en_q;
      OFS_STAT: begin
        rd_data_o[BIT_ALM]  = alm;
        rd_data_o[BIT_NV]   = nv_q;
        rd_data_o[BIT_VIOL] = viol_q;
      end
      default:   rd_data_o = '0;
    endcase
  end

  assign alarm_o = alm;

  p_nv_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nv_q) |-> $past(wr_stat && wr_data_i[1:0] == 2'b11));
  p_viol_with_nv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_q == viol_q));
endmodule

// File: tb/sim_sec_frac_timer.sv
module sim_sec_frac_timer;
  localparam time TCLK = 10ns;
  localparam int  WDOG = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        alarm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  sec_frac_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .alarm_o(alarm)
  );

  // one write = exactly one rising edge; returns just after the following falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", req, a, rd_data, exp);
    end
  endtask

  task automatic chk_alarm(input string req, input logic exp);
    checks++;
    if (alarm !== exp) begin
      errors++;
      $display("FAIL %s: alarm_o got %b expected %b", req, alarm, exp);
    end
  endtask

  typedef struct packed {
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [4:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{5'h04, 32'hFFFF_1234, 5'h04, 32'h0000_1234}, // R4 fraction load, 15 bits
    '{5'h00, 32'h0000_00AB, 5'h04, 32'h0000_1234}, // R4 seconds load keeps fraction
    '{5'h0C, 32'h0000_0007, 5'h00, 32'h0000_00AB}, // R2 seeded but not enabled
    '{5'h08, 32'h0000_0055, 5'h08, 32'h0000_0055}, // R5 alarm seconds word
    '{5'h0C, 32'hFFFF_FFFF, 5'h0C, 32'h0000_7FFF}, // R5 alarm fraction, 15 bits
    '{5'h14, 32'h0000_0002, 5'h14, 32'h0000_0003}, // R8 partial release
    '{5'h14, 32'h0000_0001, 5'h14, 32'h0000_0003}, // R8 partial release
    '{5'h10, 32'hFFFF_FFF7, 5'h04, 32'h0000_1234}, // R2 enable bit clear
    '{5'h14, 32'h0000_0003, 5'h14, 32'h0000_0000}  // R8 full release
  };

  initial begin
    int cyc = 0;
    while (!done && cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset values
    chk("R1", 5'h00, 32'h0);
    chk("R1", 5'h04, 32'h0);
    chk("R1", 5'h08, 32'hFFFF_FFFF);
    chk("R1", 5'h0C, 32'h0);
    chk("R1", 5'h10, 32'h0);
    chk("R1", 5'h14, 32'h3);
    chk_alarm("R1", 1'b0);

    // R2 enable without seeding stays frozen
    wr(5'h10, 32'h8);
    chk("R2", 5'h10, 32'h8);
    tick(5);
    chk("R2", 5'h04, 32'h0);
    wr(5'h10, 32'h0);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      chk($sformatf("vec%0d", i), VEC[i].ra, VEC[i].exp);
    end

    // R3 running with carry into seconds
    wr(5'h00, 32'h10);
    wr(5'h04, 32'h7FFD);
    wr(5'h10, 32'h8);
    chk("R3", 5'h04, 32'h7FFD);
    tick(3);
    chk("R3", 5'h00, 32'h11);
    chk("R3", 5'h04, 32'h0);

    // R4 loads while running replace the increment
    wr(5'h04, 32'h100);
    chk("R4", 5'h04, 32'h100);
    wr(5'h00, 32'h20);
    chk("R4", 5'h00, 32'h20);
    chk("R4", 5'h04, 32'h100);

    // R5 alarm rises one edge after match
    wr(5'h10, 32'h0);
    wr(5'h08, 32'h5);
    wr(5'h0C, 32'hA);
    wr(5'h00, 32'h5);
    wr(5'h04, 32'h8);
    wr(5'h10, 32'h8);
    tick(2);
    chk("R5", 5'h14, 32'h0);
    tick(1);
    chk("R5", 5'h14, 32'h10);
    chk_alarm("R5", 1'b1);

    // R6 sticky, W1C
    wr(5'h14, 32'h0);
    chk("R6", 5'h14, 32'h10);
    wr(5'h14, 32'h10);
    chk("R6", 5'h14, 32'h0);
    chk_alarm("R6", 1'b0);
    tick(5);
    chk("R6", 5'h14, 32'h0);

    // R7 held match does not re-arm
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h5);
    wr(5'h04, 32'hA);
    tick(1);
    chk("R7", 5'h14, 32'h10);
    wr(5'h14, 32'h10);
    tick(4);
    chk("R7", 5'h14, 32'h0);
    chk_alarm("R7", 1'b0);

    // R9 wrap
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h04, 32'h7FFE);
    wr(5'h10, 32'h8);
    chk("R9", 5'h00, 32'hFFFF_FFFF);
    tick(1);
    chk("R9", 5'h04, 32'h7FFF);
    tick(1);
    chk("R9", 5'h00, 32'h0);
    chk("R9", 5'h04, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule